// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor talk to Ethernet PHYs over the two-wire management bus: a clock line (MDC) that the block produces and a shared, open data line (MDIO). Software programs a PHY address and a register number, then either writes a control word to start a write frame or sets a command bit to start a read. The block sends the frame serially and, on a read, collects the sixteen returned bits into a read-data register. A set of indicator bits reports when a frame is under way, when repeated polling is active, and when the read data is still stale.

MDC is derived from the system clock through a 4-bit divider code whose ratios do not rise with the code value. The 32-bit all-ones lead-in can be switched off for PHYs that accept short frames. A polling mode re-reads one PHY register with no software involvement and keeps the read-data register fresh. A level-sensitive management reset bit aborts any activity and holds the engine idle. One further register holds a 5-bit address for an internal serdes-side PHY and resets to 0x1F.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads zero except the internal PHY address register at byte offset 0x34, which reads 0x1F; MDC is low and MDIO is not driven.
- R2: Registers sit at byte offsets 0x00 config, 0x04 command, 0x08 address, 0x0C write data, 0x10 read data, 0x14 indicator, 0x34 internal PHY address. Config keeps bit 31, bit 4 and bits 3:0. The address register keeps the PHY address in bits 12:8 and the register number in bits 4:0. The internal PHY address register keeps bits 4:0. Write data keeps bits 15:0. All other bits read zero.
- R3: Writing the write-data register starts a frame that sends, MSB first: the lead-in, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits.
- R4: With config bit 4 set the lead-in is omitted; with it clear the lead-in is 32 ones.
- R5: Config bits 3:0 set the MDC period in system clocks: code 0..F gives 2, 4, 6, 8, 10, 14, 20, 28, 16, 32, 48, 64, 80, 112, 160, 224. MDC is low when a frame begins.
- R6: Writing command bit 0 as one starts a read frame with opcode 10. The block releases MDIO from the first turnaround bit to the end of the frame and samples the 16 data bits on rising MDC. At the end it loads them into read-data bits 15:0. With no PHY answering, the pulled-up line reads 0xFFFF.
- R7: Indicator bit 0 (busy) is set from the start of a frame until its last bit has finished. While busy is clear, MDC is low and MDIO is released.
- R8: While driven, MDIO changes only on a falling MDC edge.
- R9: While command bit 1 is set the block reads the addressed register back to back, and indicator bit 1 (scan) stays set. After bit 1 is cleared, at most the frame already in progress completes, and then scan clears.
- R10: Indicator bit 2 (not valid) is set when a single read or the first read of a scan begins. It clears when that read completes.
- R11: While config bit 31 is set, any frame in progress is aborted. MDIO is released, MDC is low, the busy, scan and not-valid bits and the command register are cleared, and any start request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Byte address of the register access |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value when driven |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | Resolved MDIO line value |

## Verification
The checker assumes that software leaves the divider code and the lead-in setting unchanged while a frame is busy. It also assumes that MDIO is resolved externally, so that no other driver is active while the block drives the line. The bench rewrites config only while the busy bit is clear, or to assert the management reset. Its PHY model drives the line only in the data window of a read addressed to it, and the bench counts any overlap of both drivers as a failure.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam int CNT_W      = 7;

  typedef struct packed {
    logic                  load;
    logic                  run;
    logic                  withPre;
    logic                  capture;
    logic [3:0]            divSel;
    logic [FRAME_BITS-1:0] frameWord;
  } dpCtrl_t;

  // Half the MDC period in system clocks for each divider code.
  function automatic logic [CNT_W-1:0] halfPeriod(input logic [3:0] code);
    case (code)
      4'h0: halfPeriod = CNT_W'(1);
      4'h1: halfPeriod = CNT_W'(2);
      4'h2: halfPeriod = CNT_W'(3);
      4'h3: halfPeriod = CNT_W'(4);
      4'h4: halfPeriod = CNT_W'(5);
      4'h5: halfPeriod = CNT_W'(7);
      4'h6: halfPeriod = CNT_W'(10);
      4'h7: halfPeriod = CNT_W'(14);
      4'h8: halfPeriod = CNT_W'(8);
      4'h9: halfPeriod = CNT_W'(16);
      4'hA: halfPeriod = CNT_W'(24);
      4'hB: halfPeriod = CNT_W'(32);
      4'hC: halfPeriod = CNT_W'(40);
      4'hD: halfPeriod = CNT_W'(56);
      4'hE: halfPeriod = CNT_W'(80);
      default: halfPeriod = CNT_W'(112);
    endcase
  endfunction
endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctl,
  input  logic                 mdioIn,
  output logic                 mdc,
  output logic                 fallTick,
  output logic                 mdioOut,
  output logic [DATA_BITS-1:0] rxData
);
  localparam int SH_W = PRE_BITS + FRAME_BITS;

  logic [CNT_W-1:0] divCnt;
  logic [SH_W-1:0]  shReg;
  logic             toggle;
  logic             riseTick;

  assign toggle   = ctl.run && (divCnt == halfPeriod(ctl.divSel) - CNT_W'(1));
  assign riseTick = toggle && !mdc;
  assign fallTick = toggle && mdc;
  assign mdioOut  = shReg[SH_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      mdc    <= 1'b0;
      shReg  <= '0;
      rxData <= '0;
    end else begin
      if (!ctl.run) begin
        divCnt <= '0;
        mdc    <= 1'b0;
      end else if (toggle) begin
        divCnt <= '0;
        mdc    <= ~mdc;
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end

      if (ctl.load)
        shReg <= ctl.withPre ? {{PRE_BITS{1'b1}}, ctl.frameWord}
                             : {ctl.frameWord, {PRE_BITS{1'b0}}};
      else if (fallTick)
        shReg <= {shReg[SH_W-2:0], 1'b0};

      if (riseTick && ctl.capture)
        rxData <= {rxData[DATA_BITS-2:0], mdioIn};
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int         ADDR_W  = 6,
  parameter logic [4:0] TBI_RST = 5'h1F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [DATA_BITS-1:0] rxData,
  input  logic                 fallTick,
  output dpCtrl_t              ctl,
  output logic                 mdioOe,
  output logic                 busyInd,
  output logic                 scanInd,
  output logic                 notValidInd,
  output logic                 softRst
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int TOTAL    = PRE_BITS + FRAME_BITS;
  localparam int IDX_W    = $clog2(TOTAL + 1);
  localparam int TA_POS   = 14;
  localparam int DATA_POS = 16;
  localparam logic [WORD_W-1:0] W_CFG = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_CMD = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_ADR = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_WR  = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_RD  = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_IND = WORD_W'(5);
  localparam logic [WORD_W-1:0] W_TBI = WORD_W'(13);

  logic                 cfgRst, cfgNoPre;
  logic [3:0]           cfgDiv;
  logic [1:0]           cmdReg;
  logic [4:0]           phyAd, regAd, tbiAd;
  logic [DATA_BITS-1:0] wrData, rdData;
  logic                 pendWr, pendRd, busyQ, isRead, preQ, scanQ, notValidQ;
  logic [IDX_W-1:0]     bitIdx, preOff, frameBit, lastIdx;
  logic                 start, done, aligned;
  logic [WORD_W-1:0]    word;
  logic                 unusedWdata;

  assign unusedWdata = ^regWdata[30:16];
  assign aligned  = (regAddr[1:0] == 2'b00);
  assign word     = regAddr[ADDR_W-1:2];
  assign preOff   = preQ ? IDX_W'(PRE_BITS) : '0;
  assign frameBit = bitIdx - preOff;
  assign lastIdx  = preOff + IDX_W'(FRAME_BITS - 1);
  assign start    = !busyQ && !cfgRst && (pendWr || pendRd || cmdReg[1]);
  assign done     = busyQ && fallTick && (bitIdx == lastIdx);

  always_comb begin
    ctl.load      = start;
    ctl.run       = busyQ && !cfgRst;
    ctl.withPre   = !cfgNoPre;
    ctl.capture   = busyQ && isRead && (frameBit >= IDX_W'(DATA_POS));
    ctl.divSel    = cfgDiv;
    ctl.frameWord = {2'b01, pendWr ? 2'b01 : 2'b10, phyAd, regAd, 2'b10,
                     pendWr ? wrData : {DATA_BITS{1'b1}}};
  end

  assign mdioOe      = busyQ && !(isRead && (frameBit >= IDX_W'(TA_POS)));
  assign busyInd     = busyQ;
  assign scanInd     = scanQ;
  assign notValidInd = notValidQ;
  assign softRst     = cfgRst;

  always_comb begin
    regRdata = '0;
    if (aligned) begin
      case (word)
        W_CFG:   regRdata = {cfgRst, 26'b0, cfgNoPre, cfgDiv};
        W_CMD:   regRdata = {30'b0, cmdReg};
        W_ADR:   regRdata = {19'b0, phyAd, 3'b0, regAd};
        W_WR:    regRdata = {16'b0, wrData};
        W_RD:    regRdata = {16'b0, rdData};
        W_IND:   regRdata = {29'b0, notValidQ, scanQ, busyQ};
        W_TBI:   regRdata = {27'b0, tbiAd};
        default: regRdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRst <= 1'b0; cfgNoPre <= 1'b0; cfgDiv <= '0; cmdReg <= '0;
      phyAd <= '0; regAd <= '0; tbiAd <= TBI_RST; wrData <= '0; rdData <= '0;
      pendWr <= 1'b0; pendRd <= 1'b0; busyQ <= 1'b0; isRead <= 1'b0;
      preQ <= 1'b0; scanQ <= 1'b0; notValidQ <= 1'b0; bitIdx <= '0;
    end else begin
      // frame sequencing
      if (start) begin
        busyQ  <= 1'b1;
        bitIdx <= '0;
        preQ   <= !cfgNoPre;
        isRead <= !pendWr;
        if (pendWr) pendWr <= 1'b0;
        else if (pendRd) pendRd <= 1'b0;
        else scanQ <= 1'b1;
        if (!pendWr && !scanQ) notValidQ <= 1'b1;
      end else if (busyQ && fallTick) begin
        bitIdx <= bitIdx + IDX_W'(1);
        if (done) begin
          busyQ <= 1'b0;
          scanQ <= scanQ && cmdReg[1];
          if (isRead) begin
            rdData    <= rxData;
            notValidQ <= 1'b0;
          end
        end
      end
      // register writes
      if (regWrEn && aligned) begin
        case (word)
          W_CFG: begin
            cfgRst   <= regWdata[31];
            cfgNoPre <= regWdata[4];
            cfgDiv   <= regWdata[3:0];
          end
          W_CMD: begin
            cmdReg <= regWdata[1:0];
            if (regWdata[0]) pendRd <= 1'b1;
          end
          W_ADR: begin
            phyAd <= regWdata[12:8];
            regAd <= regWdata[4:0];
          end
          W_WR: begin
            wrData <= regWdata[DATA_BITS-1:0];
            pendWr <= 1'b1;
          end
          W_TBI:   tbiAd <= regWdata[4:0];
          default: ;
        endcase
      end
      // management reset wins over everything above
      if (cfgRst) begin
        busyQ <= 1'b0; scanQ <= 1'b0; notValidQ <= 1'b0;
        pendWr <= 1'b0; pendRd <= 1'b0; cmdReg <= '0;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  dpCtrl_t              dpCtl;
  logic                 fallTick;
  logic [DATA_BITS-1:0] rxData;
  logic                 busyInd, scanInd, notValidInd, softRst;

  mdio_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxData(rxData),
    .fallTick(fallTick), .ctl(dpCtl), .mdioOe(mdioOe), .busyInd(busyInd),
    .scanInd(scanInd), .notValidInd(notValidInd), .softRst(softRst)
  );

  mdio_datapath uDp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .mdioIn(mdioIn), .mdc(mdc),
    .fallTick(fallTick), .mdioOut(mdioOut), .rxData(rxData)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic busy,
  input logic scanning,
  input logic notValid,
  input logic softRst
);
  // R8: a driven MDIO bit only moves together with a falling MDC
  p_mdio_on_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && $past(mdioOe) && !$stable(mdioOut)) |-> $fell(mdc));

  // R7: no MDC activity outside a frame
  p_idle_mdc_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R5: every frame starts from a low MDC
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !mdc);

  // R11: management reset clears the indicators one cycle later
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!busy && !scanning && !notValid));

  // R11: management reset releases the line one cycle later
  p_soft_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !mdioOe);
endmodule

bind mdio_master mdio_master_chk uChk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busy(busyInd), .scanning(scanInd), .notValid(notValidInd), .softRst(softRst)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam logic [5:0] A_CFG = 6'h00, A_CMD = 6'h04, A_ADR = 6'h08,
                         A_WR = 6'h0C, A_RD = 6'h10, A_IND = 6'h14, A_TBI = 6'h34;
  localparam logic [4:0] PHY_ADR = 5'h05;
  localparam int NV = 8;
  // {div[3:0], ratio[7:0], isRead, noPre, phy[4:0], reg[4:0], data[15:0]}
  localparam logic [39:0] VEC [NV] = '{
    {4'h0, 8'd2,   1'b0, 1'b0, 5'h05, 5'h01, 16'hA5C3},
    {4'h5, 8'd14,  1'b1, 1'b0, 5'h05, 5'h02, 16'h1234},
    {4'h8, 8'd16,  1'b0, 1'b1, 5'h05, 5'h1F, 16'h8001},
    {4'h3, 8'd8,   1'b1, 1'b1, 5'h05, 5'h00, 16'hFFFE},
    {4'h6, 8'd20,  1'b0, 1'b0, 5'h05, 5'h0A, 16'h0F0F},
    {4'hA, 8'd48,  1'b1, 1'b0, 5'h05, 5'h0A, 16'h0F0F},
    {4'hC, 8'd80,  1'b0, 1'b1, 5'h05, 5'h07, 16'h7E7E},
    {4'hF, 8'd224, 1'b1, 1'b1, 5'h05, 5'h07, 16'h7E7E}
  };

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic mdc, mdioOut, mdioOe, mdioLine;
  logic phyOe = 1'b0, phyBit = 1'b1;

  int checks = 0, errors = 0, cycCnt = 0, collisions = 0, edgeViol = 0;
  logic prevOe = 1'b0, prevOut = 1'b0, prevMdc = 1'b0;

  // behavioural PHY state
  logic hunting = 1'b1, prevZero = 1'b0, rdReq = 1'b0;
  logic [4:0] rdReg = '0;
  int onesCnt = 0, bitNo = 0, frames = 0, lastPre = -1;
  logic [31:0] frm = '0, lastFrm = '0;
  logic [15:0] phyMem [32];
  int lastRise = -1, minPer = 0, maxPer = 0;

  always #2.5 clk = ~clk;

  assign mdioLine = mdioOe ? mdioOut : (phyOe ? phyBit : 1'b1);

  mdio_master uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioLine)
  );

  always @(negedge clk) begin
    cycCnt <= cycCnt + 1;
    if (rstN) begin
      if (mdioOe && phyOe) collisions <= collisions + 1;
      if (mdioOe && prevOe && (mdioOut != prevOut) && !(prevMdc && !mdc))
        edgeViol <= edgeViol + 1;
    end
    prevOe <= mdioOe; prevOut <= mdioOut; prevMdc <= mdc;
  end

  always @(posedge mdc) begin
    if (lastRise >= 0) begin
      if (cycCnt - lastRise < minPer) minPer = cycCnt - lastRise;
      if (cycCnt - lastRise > maxPer) maxPer = cycCnt - lastRise;
    end
    lastRise = cycCnt;
    if (hunting) begin
      if (mdioLine) begin
        if (prevZero) begin
          hunting = 1'b0; bitNo = 2; frm = 32'h1; lastPre = onesCnt; rdReq = 1'b0;
        end else onesCnt++;
        prevZero = 1'b0;
      end else prevZero = 1'b1;
    end else begin
      frm = {frm[30:0], mdioLine};
      bitNo++;
      if (bitNo == 14) begin
        rdReq = (frm[11:10] == 2'b10) && (frm[9:5] == PHY_ADR);
        rdReg = frm[4:0];
      end
      if (bitNo == 32) begin
        lastFrm = frm; frames++;
        if (frm[29:28] == 2'b01 && frm[27:23] == PHY_ADR) phyMem[frm[22:18]] = frm[15:0];
        hunting = 1'b1; onesCnt = 0; prevZero = 1'b0; rdReq = 1'b0;
      end
    end
  end

  always @(negedge mdc) begin
    if (!hunting && rdReq && bitNo >= 16 && bitNo < 32) begin
      phyOe  = 1'b1;
      phyBit = phyMem[rdReg][31-bitNo];
    end else phyOe = 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int n = 0; n < 40000; n++) begin
      regRd(A_IND, v);
      if (!v[0]) break;
    end
  endtask

  task automatic phySync();
    hunting = 1'b1; onesCnt = 0; prevZero = 1'b0; rdReq = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int f0;
    for (int k = 0; k < 32; k++) phyMem[k] = 16'(k * 16'h0101);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRd(A_CFG, v); chk("R1 cfg", v, 0);
    regRd(A_CMD, v); chk("R1 cmd", v, 0);
    regRd(A_ADR, v); chk("R1 adr", v, 0);
    regRd(A_RD, v);  chk("R1 rd", v, 0);
    regRd(A_IND, v); chk("R1 ind", v, 0);
    regRd(A_TBI, v); chk("R1 tbi", v, 32'h1F);
    chk("R1 mdc/oe", {mdc, mdioOe}, 0);

    // R2 field readback
    regWr(A_CFG, 32'h7FFF_FFFF); regRd(A_CFG, v); chk("R2 cfg mask", v, 32'h1F);
    regWr(A_CFG, 32'h0);
    regWr(A_ADR, 32'hFFFF_FFFF); regRd(A_ADR, v); chk("R2 adr mask", v, 32'h1F1F);
    regWr(A_TBI, 32'hFFFF_FFEA); regRd(A_TBI, v); chk("R2 tbi", v, 32'h0A);

    // table of frames: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      logic [3:0] dv; logic [7:0] ratio; logic isRd, noPre;
      logic [4:0] ph, rg; logic [15:0] dat;
      {dv, ratio, isRd, noPre, ph, rg, dat} = VEC[i];
      regWr(A_CFG, {27'b0, noPre, dv});
      regWr(A_ADR, {19'b0, ph, 3'b0, rg});
      if (isRd) phyMem[rg] = dat;
      minPer = 1 << 30; maxPer = 0; lastRise = -1; f0 = frames;
      if (isRd) regWr(A_CMD, 32'h1); else regWr(A_WR, {16'b0, dat});
      repeat (2) @(negedge clk);
      regRd(A_IND, v);
      chk(isRd ? "R10 ind during read" : "R7 ind during write", v, isRd ? 32'h5 : 32'h1);
      waitIdle();
      chk("R3 one frame", 32'(frames - f0), 1);
      chk("R3 opcode", 32'(lastFrm[29:28]), isRd ? 32'h2 : 32'h1);
      chk("R3 phy/reg", {lastFrm[27:18]}, {ph, rg});
      chk("R4 lead-in ones", 32'(lastPre), noPre ? 0 : 32);
      chk("R5 mdc min period", 32'(minPer), 32'(ratio));
      chk("R5 mdc max period", 32'(maxPer), 32'(ratio));
      if (isRd) begin
        chk("R6 ta released", 32'(lastFrm[17:16]), 32'h3);
        regRd(A_RD, v); chk("R6 read data", v, {16'b0, dat});
      end else begin
        chk("R3 ta", 32'(lastFrm[17:16]), 32'h2);
        chk("R3 data", 32'(phyMem[rg]), {16'b0, dat});
      end
      regRd(A_IND, v); chk("R7 idle ind", v, 0);
      chk("R7 idle mdc/oe", {mdc, mdioOe}, 0);
    end

    // R6 no responder
    regWr(A_CFG, 32'h0);
    regWr(A_ADR, {19'b0, 5'h09, 3'b0, 5'h02});
    regWr(A_CMD, 32'h1);
    repeat (2) @(negedge clk);
    waitIdle();
    regRd(A_RD, v); chk("R6 no responder", v, 32'hFFFF);

    // R9 R10 scan
    phyMem[3] = 16'hBEEF;
    regWr(A_ADR, {19'b0, PHY_ADR, 3'b0, 5'h03});
    f0 = frames;
    regWr(A_CMD, 32'h2);
    repeat (2) @(negedge clk);
    regRd(A_IND, v); chk("R10 scan first not valid", v & 32'h6, 32'h6);
    while (frames < f0 + 1) @(negedge clk);
    repeat (4) @(negedge clk);
    regRd(A_RD, v);  chk("R9 scan data 1", v, 32'hBEEF);
    regRd(A_IND, v); chk("R10 valid after first scan", v & 32'h6, 32'h2);
    phyMem[3] = 16'h1357;
    f0 = frames;
    while (frames < f0 + 2) @(negedge clk);
    repeat (4) @(negedge clk);
    regRd(A_RD, v);  chk("R9 scan data refresh", v, 32'h1357);
    regRd(A_IND, v); chk("R9 scan bit held", v & 32'h6, 32'h2);
    regWr(A_CMD, 32'h0);
    f0 = frames;
    waitIdle();
    repeat (300) @(negedge clk);
    chk("R9 stop within one frame", 32'(frames - f0 <= 1), 1);
    regRd(A_IND, v); chk("R9 scan cleared", v, 0);

    // R11 management reset
    regWr(A_CMD, 32'h0);
    regWr(A_CFG, 32'h0F);
    regWr(A_WR, 32'h5555);
    repeat (500) @(negedge clk);
    regWr(A_CFG, 32'h8000_000F);
    repeat (2) @(negedge clk);
    regRd(A_IND, v); chk("R11 abort ind", v, 0);
    chk("R11 abort line", {mdc, mdioOe}, 0);
    regWr(A_WR, 32'h1111);
    regWr(A_CMD, 32'h3);
    repeat (20) @(negedge clk);
    regRd(A_IND, v); chk("R11 hold-off ind", v, 0);
    regRd(A_CMD, v); chk("R11 cmd cleared", v, 0);
    chk("R11 hold-off line", {mdc, mdioOe}, 0);
    regWr(A_CFG, 32'h0);
    repeat (20) @(negedge clk);
    regRd(A_IND, v); chk("R11 no deferred start", v, 0);
    phySync();

    chk("R6 no bus contention", 32'(collisions), 0);
    chk("R8 mdio edge", 32'(edgeViol), 0);
    summary();
    $finish;
  end
endmodule